// File: doc/BRIEF.md
# Audio Bit Clock Divider

This block derives the serial audio bit clock and the word-select (frame) clock for a two-channel serial audio port. It counts edge events from one of two master audio clock sources, divides them by a ratio picked through a 4-bit code, and shapes the result into a bit clock. The word-select clock runs at the bit-clock rate divided by 64, which gives one 32-bit slot per channel. A serializer next to the block uses the one-cycle bit strobe to shift data. The bit-clock rate therefore equals the sample rate times 64.

Each master clock source is presented in the block clock domain as an edge strobe: one strobe for every edge of that master clock. The bit clock toggles after every N strobes of the selected source, where N is the decoded ratio. This makes ratio 1 a gated copy of the master clock. A divider code that changes during a frame only takes effect at the next frame boundary. The master-enable input is sampled only while the clock enable is low. A keep-running input holds both clocks active while no transfer is enabled.

Top module: `audclk_div`

## Requirements
- R1: Codes 0 to 7 on `div_code` select ratio N = 1, 2, 4, 8, 16, 32, 64, 128. The bit clock toggles after every N selected source strobes, so `bit_strobe` repeats every 2N source strobes.
- R2: Codes 8 to 12 select ratio N = 6, 12, 24, 48, 96, with the same toggle rule as R1.
- R3: Codes 13, 14 and 15 are invalid. With such a code in effect, `code_err` is 1, the bit clock stays at its idle level and no `bit_strobe` is produced.
- R4: With `src_sel` = 1 the block counts `src_a_edge`; with `src_sel` = 0 it counts `src_b_edge`.
- R5: The unpolarised word-select clock is 0 for 32 bit periods and then 1 for 32 bit periods. It changes only in a cycle in which `bit_strobe` is 1, and its period is 64 bit periods.
- R6: A change of `div_code` while running is applied only at the frame boundary, which is the falling edge of the unpolarised word-select clock. Earlier bit periods keep the old ratio.
- R7: The clocks run when `master_en`, `clk_en` and either `xfer_en` or `keep_frame` are active. With both `xfer_en` and `keep_frame` at 0, the clocks return to their idle levels and all counters clear.
- R8: `master_en` is captured only in cycles with `clk_en` = 0. A change of `master_en` while `clk_en` = 1 has no effect.
- R9: `bck_inv` = 1 inverts `bck` and `ws_inv` = 1 inverts `ws`. The idle levels are `bck` = `bck_inv` and `ws` = `ws_inv`.
- R10: `bit_strobe` is a one-cycle pulse issued in the same cycle as the unpolarised bit clock falls. After reset, `bck`, `ws`, `bit_strobe` and `code_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_a_edge | input | 1 | Edge strobe of master clock source A |
| src_b_edge | input | 1 | Edge strobe of master clock source B |
| src_sel | input | 1 | 1 selects source A, 0 selects source B |
| div_code | input | 4 | Encoded division ratio |
| master_en | input | 1 | Clock generation enable, sampled while clk_en is 0 |
| clk_en | input | 1 | Audio clock enable |
| xfer_en | input | 1 | Transmit or receive active |
| keep_frame | input | 1 | Keep clocks running with no transfer |
| bck_inv | input | 1 | Bit clock polarity |
| ws_inv | input | 1 | Word-select polarity |
| bck | output | 1 | Bit clock |
| ws | output | 1 | Word-select clock |
| bit_strobe | output | 1 | One-cycle pulse at each bit-clock fall |
| code_err | output | 1 | Divider code in effect is invalid |

## Verification
The divider is driven with source A strobing every cycle for power-of-two codes up to the largest ratio and for the multiple-of-six codes. Each measured strobe period separates a wrong decode from a wrong counter end value. Source B strobing every other cycle doubles the expected period, which shows that the select input picks the correct stream. A code change made at the start of a frame's second half must leave that half at the old period and switch exactly at the falling word-select edge, which separates frame-aligned loading from immediate loading. Invalid codes, keep-running, the master-enable capture window and both polarities are each tried as separate scenarios, with both outputs observed.

// File: rtl/audclk_pkg.sv
// Package: shared constants and the divider-code decode for the audio clock divider.
// Assumes a 4-bit code; reserved codes decode to a ratio of 0.
package audclk_pkg;
    localparam int CODE_W = 4;

    // Decode a divider code into its ratio; 0 marks a reserved code.
    function automatic int unsigned code_ratio(input logic [CODE_W-1:0] c);
        if (c < 4'd8)
            return 32'd1 << c;
        else if (c <= 4'd12)
            return 32'd6 << (c - 4'd8);
        else
            return 32'd0;
    endfunction
endpackage

// File: rtl/audclk_src_pick.sv
// Module: selects which master clock edge strobe drives the divider.
// Assumes both strobes are already in the block clock domain.
module audclk_src_pick (
    input  logic sel,
    input  logic edge_a,
    input  logic edge_b,
    output logic tick
);
    // Pick source A when sel is 1, source B otherwise.
    always_comb tick = sel ? edge_a : edge_b;
endmodule

// File: rtl/audclk_edge_div.sv
// Module: divides source edge strobes into the raw bit clock.
// Toggles the bit clock after every 'ratio' strobes and reports each falling edge.
// Assumes ratio >= 1 whenever run is high.
module audclk_edge_div #(
    parameter int RW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          tick,
    input  logic [RW-1:0] ratio,
    output logic          bck_raw,
    output logic          fall_now,
    output logic          strobe
);
    logic [RW-1:0] cnt_q;
    logic          hit;

    // Terminal count of the current half period.
    always_comb hit = (cnt_q == ratio - RW'(1));
    // Falling edge happens on this tick.
    always_comb fall_now = tick & hit & bck_raw;

    // Half-period counter, bit clock phase and strobe register.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q   <= '0;
            bck_raw <= 1'b0;
            strobe  <= 1'b0;
        end else begin
            strobe <= fall_now;
            if (tick) begin
                if (hit) begin
                    cnt_q   <= '0;
                    bck_raw <= ~bck_raw;
                end else begin
                    cnt_q <= cnt_q + RW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/audclk_frame_cnt.sv
// Module: counts bit periods within a frame and forms the raw word-select clock.
// First slot drives word-select low, second slot high; wraps at the frame end.
module audclk_frame_cnt #(
    parameter int SLOT_BITS = 32,
    parameter int CHANNELS  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic advance,
    output logic ws_raw,
    output logic wrap_now
);
    localparam int FRAME_BITS = SLOT_BITS * CHANNELS;
    localparam int FW         = $clog2(FRAME_BITS);

    logic [FW-1:0] bit_q;

    // Last bit of the frame ends on this advance.
    always_comb wrap_now = advance & (bit_q == FW'(FRAME_BITS - 1));
    // Word select is high in the second slot.
    always_comb ws_raw = (bit_q >= FW'(SLOT_BITS));

    // Bit-period counter within the frame.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            bit_q <= '0;
        else if (wrap_now)
            bit_q <= '0;
        else if (advance)
            bit_q <= bit_q + FW'(1);
    end
endmodule

// File: rtl/audclk_div.sv
// Module: top of the audio bit clock divider.
// Holds the captured master enable and the divider code in effect, gates the
// run condition and applies output polarity. Assumes master strobes arrive in clk domain.
module audclk_div #(
    parameter int MAX_RATIO = 128,
    parameter int SLOT_BITS = 32,
    parameter int CHANNELS  = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       src_a_edge,
    input  logic                       src_b_edge,
    input  logic                       src_sel,
    input  logic [audclk_pkg::CODE_W-1:0] div_code,
    input  logic                       master_en,
    input  logic                       clk_en,
    input  logic                       xfer_en,
    input  logic                       keep_frame,
    input  logic                       bck_inv,
    input  logic                       ws_inv,
    output logic                       bck,
    output logic                       ws,
    output logic                       bit_strobe,
    output logic                       code_err
);
    localparam int RW = $clog2(MAX_RATIO + 1);

    logic                          master_q;
    logic [audclk_pkg::CODE_W-1:0] cur_code;
    logic [RW-1:0]                 ratio;
    logic                          code_ok;
    logic                          run;
    logic                          tick;
    logic                          bck_raw;
    logic                          fall_now;
    logic                          ws_raw;
    logic                          frame_wrap;

    // Decode the code in effect.
    always_comb begin
        ratio   = RW'(audclk_pkg::code_ratio(cur_code));
        code_ok = (audclk_pkg::code_ratio(cur_code) != 0);
    end

    // Clocks run only when enabled, in use and with a valid ratio.
    always_comb run = master_q & clk_en & (xfer_en | keep_frame) & code_ok;

    // Capture master enable only while the audio clock enable is low.
    always_ff @(posedge clk) begin
        if (!rst_n)
            master_q <= 1'b0;
        else if (!clk_en)
            master_q <= master_en;
    end

    // Load a new divider code while stopped or at a frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_code <= '0;
        else if (!run || frame_wrap)
            cur_code <= div_code;
    end

    audclk_src_pick u_pick (
        .sel    (src_sel),
        .edge_a (src_a_edge),
        .edge_b (src_b_edge),
        .tick   (tick)
    );

    audclk_edge_div #(.RW(RW)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .tick     (tick),
        .ratio    (ratio),
        .bck_raw  (bck_raw),
        .fall_now (fall_now),
        .strobe   (bit_strobe)
    );

    audclk_frame_cnt #(.SLOT_BITS(SLOT_BITS), .CHANNELS(CHANNELS)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .advance  (fall_now),
        .ws_raw   (ws_raw),
        .wrap_now (frame_wrap)
    );

    // Apply polarity and report an invalid code.
    always_comb begin
        bck      = bck_raw ^ bck_inv;
        ws       = ws_raw ^ ws_inv;
        code_err = ~code_ok;
    end
endmodule

// File: rtl/audclk_div_chk.sv
// Module: property checker for audclk_div, attached by bind.
module audclk_div_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       clk_en,
    input logic       bck,
    input logic       bck_inv,
    input logic       bit_strobe,
    input logic       code_err,
    input logic       master_q,
    input logic [3:0] cur_code,
    input logic       frame_wrap,
    input logic       run,
    input logic       ws_raw
);
    AST_ERR_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n) code_err |-> (bck == bck_inv)); // R3
    AST_ERR_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n) $past(code_err) |-> !bit_strobe); // R3
    AST_WS_MOVES_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n) ($past(run) && !$stable(ws_raw)) |-> bit_strobe); // R5
    AST_CODE_HELD_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n) ($past(run) && !$past(frame_wrap)) |-> $stable(cur_code)); // R6
    AST_MASTER_HELD: assert property (@(posedge clk) disable iff (!rst_n) $past(clk_en) |-> $stable(master_q)); // R8
    AST_STROBE_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n) bit_strobe |-> (bck == bck_inv)); // R10
endmodule

bind audclk_div audclk_div_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_en     (clk_en),
    .bck        (bck),
    .bck_inv    (bck_inv),
    .bit_strobe (bit_strobe),
    .code_err   (code_err),
    .master_q   (master_q),
    .cur_code   (cur_code),
    .frame_wrap (frame_wrap),
    .run        (run),
    .ws_raw     (ws_raw)
);

// File: tb/audclk_div_test.sv
module audclk_div_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       src_a_edge = 1'b1;
    logic       src_b_edge = 1'b0;
    logic       src_sel = 1'b1;
    logic [3:0] div_code = 4'd0;
    logic       master_en = 1'b0;
    logic       clk_en = 1'b0;
    logic       xfer_en = 1'b0;
    logic       keep_frame = 1'b0;
    logic       bck_inv = 1'b0;
    logic       ws_inv = 1'b0;
    logic       bck, ws, bit_strobe, code_err;

    int nchk = 0;
    int nerr = 0;
    int cyc = 0;
    int last_t = -1;
    bit mon_on = 1'b0;
    bit finished = 1'b0;
    int    exp_q[$];
    string tag_q[$];

    audclk_div uut (
        .clk(clk), .rst_n(rst_n), .src_a_edge(src_a_edge), .src_b_edge(src_b_edge),
        .src_sel(src_sel), .div_code(div_code), .master_en(master_en), .clk_en(clk_en),
        .xfer_en(xfer_en), .keep_frame(keep_frame), .bck_inv(bck_inv), .ws_inv(ws_inv),
        .bck(bck), .ws(ws), .bit_strobe(bit_strobe), .code_err(code_err)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc++;
    always @(negedge clk) src_b_edge <= ~src_b_edge;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ref_ratio(input int code);
        case (code)
            0: return 1;   1: return 2;   2: return 4;   3: return 8;
            4: return 16;  5: return 32;  6: return 64;  7: return 128;
            8: return 6;   9: return 12;  10: return 24; 11: return 48;
            12: return 96;
            default: return 0;
        endcase
    endfunction

    // Monitor: pops expected strobe periods and compares with measured ones.
    always @(negedge clk) begin
        if (mon_on && bit_strobe) begin
            if (last_t >= 0 && exp_q.size() > 0) begin
                int e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check((cyc - last_t) == e, t, cyc - last_t, e);
            end
            last_t = cyc;
        end
    end

    // Driver: configure a code and source, push expected periods, run until consumed.
    task automatic run_ratio(input int code, input bit sel, input int n, input string req);
        @(negedge clk);
        xfer_en = 1'b0;
        div_code = 4'(code);
        src_sel = sel;
        repeat (3) @(negedge clk);
        last_t = -1;
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(2 * ref_ratio(code) * (sel ? 1 : 2));
            tag_q.push_back(req);
        end
        mon_on = 1'b1;
        xfer_en = 1'b1;
        while (exp_q.size() > 0) @(negedge clk);
        mon_on = 1'b0;
        xfer_en = 1'b0;
    endtask

    task automatic count_strobes(input int win, output int n);
        n = 0;
        for (int i = 0; i < win; i++) begin
            @(negedge clk);
            if (bit_strobe) n++;
        end
    endtask

    initial begin
        int n, t_rise, t_fall, prev_ws, bad, post, pre_iv;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check(bck == 0 && ws == 0 && bit_strobe == 0 && code_err == 0, "R10 reset",
              {bck, ws, bit_strobe, code_err}, 0);

        master_en = 1'b1;
        @(negedge clk);
        clk_en = 1'b1;

        // R1: power-of-two ratios
        run_ratio(0, 1'b1, 4, "R1 code0");
        run_ratio(3, 1'b1, 4, "R1 code3");
        run_ratio(7, 1'b1, 3, "R1 code7");
        // R2: multiple-of-six ratios
        run_ratio(8, 1'b1, 4, "R2 code8");
        run_ratio(12, 1'b1, 3, "R2 code12");
        // R4: source B selected (strobes every other cycle)
        run_ratio(1, 1'b0, 4, "R4 srcB code1");

        // R5: word-select timing with code 0 (bit period 2 cycles)
        @(negedge clk);
        div_code = 4'd0; src_sel = 1'b1;
        repeat (3) @(negedge clk);
        xfer_en = 1'b1;
        prev_ws = ws;
        t_rise = -1; t_fall = -1;
        while (t_rise < 0) begin
            @(negedge clk);
            if (ws && !prev_ws) t_rise = cyc;
            prev_ws = ws;
        end
        while (1) begin
            @(negedge clk);
            if (!ws && prev_ws) t_fall = cyc;
            if (ws && !prev_ws) break;
            prev_ws = ws;
        end
        check(t_fall - t_rise == 64, "R5 ws high time", t_fall - t_rise, 64);
        check(cyc - t_rise == 128, "R5 ws period", cyc - t_rise, 128);

        // R6: change code at the start of the high slot; applies at ws fall
        div_code = 4'd1;
        last_t = cyc;
        prev_ws = 1;
        bad = 0; post = 0; pre_iv = 0;
        while (post < 3) begin
            @(negedge clk);
            if (bit_strobe) begin
                if (prev_ws == 1) begin
                    if (cyc - last_t != 2) begin bad++; pre_iv = cyc - last_t; end
                end else begin
                    check(cyc - last_t == 4, "R6 new ratio after boundary", cyc - last_t, 4);
                    post++;
                end
                last_t = cyc;
            end
            if (!ws) prev_ws = 0;
        end
        check(bad == 0, "R6 old ratio kept in frame", pre_iv, 2);
        xfer_en = 1'b0;

        // R3: invalid codes
        foreach (exp_q[i]) exp_q.delete();
        div_code = 4'd13;
        repeat (3) @(negedge clk);
        xfer_en = 1'b1;
        @(negedge clk);
        check(code_err == 1, "R3 err code13", code_err, 1);
        bad = 0; n = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (bit_strobe) n++;
            if (bck) bad++;
        end
        check(n == 0, "R3 no strobe", n, 0);
        check(bad == 0, "R3 bck idle", bad, 0);
        div_code = 4'd15;
        repeat (2) @(negedge clk);
        check(code_err == 1, "R3 err code15", code_err, 1);
        xfer_en = 1'b0;

        // R7: keep-running without transfer
        div_code = 4'd0;
        repeat (3) @(negedge clk);
        keep_frame = 1'b1;
        repeat (10) @(negedge clk);
        count_strobes(40, n);
        check(n == 20, "R7 keep running", n, 20);
        // R8: master enable change ignored while clk_en is high
        master_en = 1'b0;
        repeat (4) @(negedge clk);
        count_strobes(40, n);
        check(n == 20, "R8 master change ignored", n, 20);
        clk_en = 1'b0;
        repeat (3) @(negedge clk);
        clk_en = 1'b1; master_en = 1'b1;
        count_strobes(30, n);
        check(n == 0, "R8 captured off stays off", n, 0);
        clk_en = 1'b0;
        @(negedge clk);
        clk_en = 1'b1;
        repeat (6) @(negedge clk);
        count_strobes(40, n);
        check(n == 20, "R8 recaptured on", n, 20);
        // R7: both off returns to idle
        keep_frame = 1'b0;
        repeat (2) @(negedge clk);
        count_strobes(20, n);
        check(n == 0 && bck == 0 && ws == 0, "R7 idle when unused", n + bck + ws, 0);

        // R9: polarity
        bck_inv = 1'b1; ws_inv = 1'b1;
        @(negedge clk);
        check(bck == 1 && ws == 1, "R9 idle levels", {bck, ws}, 3);
        xfer_en = 1'b1;
        n = 0;
        while (n == 0) begin
            @(negedge clk);
            if (bit_strobe) n = 1;
        end
        check(bck == 1, "R9 inverted bck at strobe", bck, 1);
        check(ws == 1, "R9 inverted ws in first slot", ws, 1);
        xfer_en = 1'b0;
        repeat (3) @(negedge clk);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    // Watchdog
    initial begin
        #(8 * 150000);
        if (!finished) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end
endmodule